// File: doc/BRIEF.md
# Probe-Addressed Array Test Scan Controller

This block is the test-access logic of an unconfigured programmable logic array. A serial register runs around the die edge. A tester shifts a configuration word into it, and can read back either the previous contents or a captured snapshot. The word names one internal source for each of two dedicated probe pins. A source can be any logic-module output, the input-buffer level of any pad, the level actually driven toward any pad, or the level seen at the array edge for each clock buffer. The word also selects a common override for every pad's output buffer: drive low, drive high or float. This lets a tester run output-level and leakage measurements.

Shifting changes only the serial register. The probe selections and the buffer override take effect only on an explicit update strobe, so the probe pins stay steady while bits move through the chain. When test mode is off, both probe pins float, every pad follows the core, and the active selection returns to zero.

The scan port is a plain synchronous serial interface with no valid/ready handshake. The tester owns the pacing and cannot be stalled, so the block has no back-pressure.

Top module: `array_probe_scan`

## Requirements
- R1: While test_en and scan_shift are high, each clock moves the 14-bit chain one place toward bit 0. scan_in enters bit 13, and scan_out always shows bit 0. A word is therefore loaded least significant bit first, and the old contents leave least significant bit first.
- R2: Chain fields: bits [1:0] hold the pad mode, bits [6:2] the probe A source index, bits [11:7] the probe B source index. Bits [13:12] are a capture field for the clock-edge levels and have no effect on outputs.
- R3: The active mode and selections change only in a cycle with test_en and scan_update high, and then take the chain contents from before that edge. Shifting or capturing without an update leaves the probe and pad outputs unchanged.
- R4: Source index map: 0–15 are logic-module outputs mod_out[i]; 16–19 are pad input levels pad_in[i-16]; 20–23 are the driven pad levels pad_out[i-20], after any override; 24–25 are clk_edge[i-24]; 26–31 read as 0. A probe follows its source combinationally.
- R5: Probe A and probe B are selected independently and may observe the same source.
- R6: Pad mode 00 passes core_out/core_oe through, 01 drives every pad low with enable 1, 10 drives every pad high with enable 1, and 11 drops every enable to 0 with data 0.
- R7: scan_capture with test_en high and scan_shift low loads the chain with {clk_edge, active B index, active A index, active mode}. scan_shift takes priority over scan_capture.
- R8: With test_en low: probe_a_oe and probe_b_oe are 0 and both probes read 0; pads pass core_out/core_oe; the active mode and selections are cleared to 0; shift and capture requests leave the chain unchanged.
- R9: After reset the chain and the active selection are all zero, so scan_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Active-low synchronous reset |
| test_en | input | 1 | Test mode enable |
| scan_in | input | 1 | Serial data into the chain |
| scan_shift | input | 1 | Shift the chain one place |
| scan_capture | input | 1 | Parallel-load the chain for readback |
| scan_update | input | 1 | Transfer chain fields to the active selection |
| scan_out | output | 1 | Serial data out of the chain (bit 0) |
| mod_out | input | 16 | Logic-module outputs |
| pad_in | input | 4 | Pad input-buffer levels |
| core_out | input | 4 | Core-driven pad data |
| core_oe | input | 4 | Core-driven pad enables |
| clk_edge | input | 2 | Clock-buffer levels at the array edge |
| probe_a | output | 1 | Probe A value |
| probe_a_oe | output | 1 | Probe A drive enable |
| probe_b | output | 1 | Probe B value |
| probe_b_oe | output | 1 | Probe B drive enable |
| pad_out | output | 4 | Pad data after override |
| pad_oe | output | 4 | Pad enable after override |

## Verification
On every cycle, the in-line properties check four things. The chain and the active selection hold when nothing requests a change. Pads follow the core and both probes float whenever test mode is off. The float mode clears every pad enable. Only the bench scenarios can show the rest: serial ordering and readback of a whole word, the mapping of each index range to its source (including the driven pad levels under each override and the zero above the range), independence of the two probes, and capture of the clock-edge levels.

// File: rtl/array_probe_scan_pkg.sv
package array_probe_scan_pkg;
  typedef enum logic [1:0] {
    PM_PASS  = 2'b00,
    PM_LOW   = 2'b01,
    PM_HIGH  = 2'b10,
    PM_FLOAT = 2'b11
  } pad_mode_e;
endpackage

// File: rtl/aps_chain.sv
module aps_chain
  import array_probe_scan_pkg::*;
#(
  parameter int SEL_W = 5,
  parameter int N_CLK = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             test_en,
  input  logic             scan_in,
  input  logic             scan_shift,
  input  logic             scan_capture,
  input  logic             scan_update,
  input  logic [N_CLK-1:0] clk_edge,
  output logic             scan_out,
  output logic [SEL_W-1:0] sel_a,
  output logic [SEL_W-1:0] sel_b,
  output pad_mode_e        mode
);
  localparam int CFG_W = 2 + 2 * SEL_W;
  localparam int CH_W  = CFG_W + N_CLK;

  logic [CH_W-1:0] chain;

  // Serial register: shift wins over capture; frozen outside test mode (R1, R7, R8)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '0;
    end else if (test_en) begin
      if (scan_shift)
        chain <= {scan_in, chain[CH_W-1:1]};
      else if (scan_capture)
        chain <= {clk_edge, sel_b, sel_a, mode};
    end
  end

  // Active selection: changes only on update, cleared when test mode is off (R3, R8)
  always_ff @(posedge clk) begin
    if (!rst_n || !test_en) begin
      sel_a <= '0;
      sel_b <= '0;
      mode  <= PM_PASS;
    end else if (scan_update) begin
      mode  <= pad_mode_e'(chain[1:0]);
      sel_a <= chain[2 +: SEL_W];
      sel_b <= chain[2 + SEL_W +: SEL_W];
    end
  end

  assign scan_out = chain[0];

  // R1/R7: with no request the chain keeps its contents
  a_r1_chain_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_shift && !scan_capture) |=> $stable(chain));

  // R3: selection stable unless an update is applied
  a_r3_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (test_en && !scan_update) |=> ($stable(sel_a) && $stable(sel_b) && $stable(mode)));
endmodule

// File: rtl/aps_probe_mux.sv
module aps_probe_mux #(
  parameter int N_SRC = 26,
  parameter int SEL_W = 5
) (
  input  logic [N_SRC-1:0] src,
  input  logic [SEL_W-1:0] sel,
  input  logic             en,
  output logic             probe,
  output logic             probe_oe
);
  localparam int FULL = 1 << SEL_W;

  logic [FULL-1:0] src_ext;

  // Indices past the last source read as zero (R4)
  assign src_ext  = FULL'(src);
  assign probe    = en & src_ext[sel];
  assign probe_oe = en;
endmodule

// File: rtl/aps_pad_override.sv
module aps_pad_override
  import array_probe_scan_pkg::*;
#(
  parameter int N_PAD = 4
) (
  input  logic             test_en,
  input  pad_mode_e        mode,
  input  logic [N_PAD-1:0] core_out,
  input  logic [N_PAD-1:0] core_oe,
  output logic [N_PAD-1:0] pad_out,
  output logic [N_PAD-1:0] pad_oe
);
  for (genvar p = 0; p < N_PAD; p++) begin : g_pad
    always_comb begin
      pad_out[p] = core_out[p];
      pad_oe[p]  = core_oe[p];
      if (test_en) begin
        case (mode)
          PM_LOW:   begin pad_out[p] = 1'b0; pad_oe[p] = 1'b1; end
          PM_HIGH:  begin pad_out[p] = 1'b1; pad_oe[p] = 1'b1; end
          PM_FLOAT: begin pad_out[p] = 1'b0; pad_oe[p] = 1'b0; end
          default:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/array_probe_scan.sv
module array_probe_scan
  import array_probe_scan_pkg::*;
#(
  parameter int N_MOD = 16,
  parameter int N_PAD = 4,
  parameter int N_CLK = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             test_en,
  input  logic             scan_in,
  input  logic             scan_shift,
  input  logic             scan_capture,
  input  logic             scan_update,
  output logic             scan_out,
  input  logic [N_MOD-1:0] mod_out,
  input  logic [N_PAD-1:0] pad_in,
  input  logic [N_PAD-1:0] core_out,
  input  logic [N_PAD-1:0] core_oe,
  input  logic [N_CLK-1:0] clk_edge,
  output logic             probe_a,
  output logic             probe_a_oe,
  output logic             probe_b,
  output logic             probe_b_oe,
  output logic [N_PAD-1:0] pad_out,
  output logic [N_PAD-1:0] pad_oe
);
  localparam int N_SRC = N_MOD + 2 * N_PAD + N_CLK;
  localparam int SEL_W = $clog2(N_SRC);

  logic [SEL_W-1:0] sel_a, sel_b;
  pad_mode_e        mode;
  logic [N_SRC-1:0] src;

  aps_chain #(.SEL_W(SEL_W), .N_CLK(N_CLK)) u_chain (
    .clk, .rst_n, .test_en, .scan_in, .scan_shift, .scan_capture,
    .scan_update, .clk_edge, .scan_out, .sel_a, .sel_b, .mode
  );

  aps_pad_override #(.N_PAD(N_PAD)) u_pads (
    .test_en, .mode, .core_out, .core_oe, .pad_out, .pad_oe
  );

  // Source order: modules, pad inputs, driven pad levels, clock edges (R4)
  assign src = {clk_edge, pad_out, pad_in, mod_out};

  aps_probe_mux #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_probe_a (
    .src, .sel(sel_a), .en(test_en), .probe(probe_a), .probe_oe(probe_a_oe)
  );

  aps_probe_mux #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_probe_b (
    .src, .sel(sel_b), .en(test_en), .probe(probe_b), .probe_oe(probe_b_oe)
  );

  a_r8_pads_released: assert property (@(posedge clk) disable iff (!rst_n)
    !test_en |-> (pad_oe == core_oe && pad_out == core_out));

  a_r8_probes_float: assert property (@(posedge clk) disable iff (!rst_n)
    !test_en |-> (!probe_a_oe && !probe_b_oe && !probe_a && !probe_b));

  a_r6_float_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (test_en && mode == PM_FLOAT) |-> (pad_oe == '0));
endmodule

// File: tb/array_probe_scan_test.sv
module array_probe_scan_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic test_en = 1'b0, scan_in = 1'b0, scan_shift = 1'b0, scan_capture = 1'b0, scan_update = 1'b0;
  logic scan_out;
  logic [15:0] mod_v = '0;
  logic [3:0]  pin_v = '0, cout_v = '0, coe_v = '0;
  logic [1:0]  clk_v = '0;
  logic probe_a, probe_a_oe, probe_b, probe_b_oe;
  logic [3:0] pad_out, pad_oe;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [13:0] last_word = '0;
  logic [1:0]  act_mode = '0;
  logic [4:0]  act_a = '0, act_b = '0;

  always #10 clk = ~clk;

  array_probe_scan uut (
    .clk, .rst_n, .test_en, .scan_in, .scan_shift, .scan_capture, .scan_update,
    .scan_out, .mod_out(mod_v), .pad_in(pin_v), .core_out(cout_v), .core_oe(coe_v),
    .clk_edge(clk_v), .probe_a, .probe_a_oe, .probe_b, .probe_b_oe, .pad_out, .pad_oe
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_pout(logic [1:0] m);
    case (m)
      2'b01: return 4'h0;
      2'b10: return 4'hF;
      2'b11: return 4'h0;
      default: return cout_v;
    endcase
  endfunction

  function automatic logic [3:0] exp_poe(logic [1:0] m);
    case (m)
      2'b01, 2'b10: return 4'hF;
      2'b11: return 4'h0;
      default: return coe_v;
    endcase
  endfunction

  function automatic logic exp_src(logic [4:0] idx, logic [1:0] m);
    logic [25:0] s;
    s = {clk_v, exp_pout(m), pin_v, mod_v};
    return (idx < 26) ? s[idx] : 1'b0;
  endfunction

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic shift_word(logic [13:0] w, output logic [13:0] got);
    for (int i = 0; i < 14; i++) begin
      scan_in = w[i]; scan_shift = 1'b1;
      #1 got[i] = scan_out;
      tick();
    end
    scan_shift = 1'b0;
  endtask

  task automatic pulse_update();
    scan_update = 1'b1; tick(); scan_update = 1'b0;
  endtask

  task automatic randomize_inputs();
    mod_v = 16'($urandom); pin_v = 4'($urandom);
    cout_v = 4'($urandom); coe_v = 4'($urandom); clk_v = 2'($urandom);
  endtask

  task automatic check_outputs(string tag);
    #1;
    check({tag, " R4 R5 probe_a"}, 32'(probe_a), 32'(exp_src(act_a, act_mode)));
    check({tag, " R4 R5 probe_b"}, 32'(probe_b), 32'(exp_src(act_b, act_mode)));
    check({tag, " R6 pad_out"}, 32'(pad_out), 32'(exp_pout(act_mode)));
    check({tag, " R6 pad_oe"}, 32'(pad_oe), 32'(exp_poe(act_mode)));
  endtask

  task automatic load_and_apply(logic [13:0] w, string tag);
    logic [13:0] got;
    logic pa, pb;
    logic [3:0] po;
    #1 pa = probe_a; pb = probe_b; po = pad_out;
    shift_word(w, got);
    check({tag, " R1 readback"}, 32'(got), 32'(last_word));
    last_word = w;
    #1;
    check({tag, " R3 probe_a held"}, 32'(probe_a), 32'(pa));
    check({tag, " R3 probe_b held"}, 32'(probe_b), 32'(pb));
    check({tag, " R3 pads held"}, 32'(pad_out), 32'(po));
    pulse_update();
    act_mode = w[1:0]; act_a = w[6:2]; act_b = w[11:7];
    check_outputs({tag, " R2"});
  endtask

  initial begin
    logic [13:0] got;
    void'($urandom(32'd1234));
    tick(); tick();
    rst_n = 1'b1;
    #1;
    check("R9 scan_out reset", 32'(scan_out), 32'h0);
    check("R8 probe oe off", 32'({probe_a_oe, probe_b_oe}), 32'h0);
    cout_v = 4'hA; coe_v = 4'h5; #1;
    check("R8 pads pass", 32'({pad_out, pad_oe}), 32'hA5);

    test_en = 1'b1;
    tick();
    #1 check("R8 probe oe on", 32'({probe_a_oe, probe_b_oe}), 32'h3);

    // Directed corners
    randomize_inputs();
    load_and_apply({2'b00, 5'd25, 5'd24, 2'b00}, "clk edges");
    load_and_apply({2'b11, 5'd26, 5'd31, 2'b10}, "out of range, high");
    load_and_apply({2'b00, 5'd20, 5'd23, 2'b01}, "pad drive, low");
    load_and_apply({2'b00, 5'd17, 5'd17, 2'b11}, "same src, float");
    load_and_apply({2'b00, 5'd21, 5'd0, 2'b00}, "pass");

    // Random configurations
    for (int k = 0; k < 40; k++) begin
      randomize_inputs();
      load_and_apply(14'($urandom), "random");
      randomize_inputs();
      check_outputs("random inputs");
    end

    // Capture then shift out (R7)
    randomize_inputs();
    scan_capture = 1'b1; tick(); scan_capture = 1'b0;
    shift_word(14'h0, got);
    check("R7 capture", 32'(got), 32'({clk_v, act_b, act_a, act_mode}));
    last_word = 14'h0;

    // Shift beats capture (R7)
    scan_capture = 1'b1;
    shift_word(14'h2A5C, got);
    scan_capture = 1'b0;
    last_word = 14'h2A5C;
    shift_word(14'h1111, got);
    check("R7 shift priority", 32'(got), 32'h2A5C);
    last_word = 14'h1111;

    // Test mode off: requests ignored, selection cleared (R8)
    pulse_update();
    test_en = 1'b0;
    shift_word(14'h3FFF, got);
    scan_capture = 1'b1; scan_update = 1'b1; tick(); scan_capture = 1'b0; scan_update = 1'b0;
    #1 check("R8 probes low", 32'({probe_a, probe_b}), 32'h0);
    check("R8 pads pass off", 32'({pad_out, pad_oe}), 32'({cout_v, coe_v}));
    test_en = 1'b1; tick();
    act_mode = 2'b00; act_a = 5'd0; act_b = 5'd0;
    check_outputs("R8 cleared selection");
    shift_word(14'h0, got);
    check("R8 chain frozen", 32'(got), 32'(last_word));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule